// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Mapper

This block steers a micro-coded processor. It asks for an instruction word and turns the word into a starting address in control memory. It then walks the control words of that routine one at a time, reading each one from a synchronous control memory and holding it in a 24-bit control data register for the datapath. Instruction fetch is not stored as micro-code: the sequencer raises a fetch request by itself whenever the current routine has finished.

Each control word carries an end-of-routine flag in bit 0. When the flag is set, the next step is a fresh instruction fetch. When it is clear, the control address advances by one and the following word is read. A word of all zeros drives no datapath action and only advances the control address. An instruction that maps to control address 0x00 is a halt. It stops all sequencing until the next reset.

Top module: `useq_sequencer`

## Requirements
- R1: While reset is asserted, cm_addr_o is 0, cdr_o is 0, and ctrl_valid_o and halt_o are low. In the first cycle after reset is released, fetch_req_o is high.
- R2: When instr_i[14:12] is in 1..7, the word is a memory-reference instruction, and bit 15 selects the indirect entry. The direct entries for opcodes 1..7 are 0x03, 0x05, 0x07, 0x09, 0x0C, 0x0F, 0x12. The indirect entries for opcodes 1..7 are 0x17, 0x1A, 0x1D, 0x21, 0x24, 0x27, 0x2A.
- R3: When instr_i[15:12] is 0x0, instr_i[11:8] selects the entry. Selectors 0..F map in order to 30, 32, 34, 4A, 36, 9A, 46, 3C, 38, 3A, 3E, 40, 48, 42, 44, 00 (all hex).
- R4: When instr_i[15:12] is 0x8, instr_i[11:8] selects the entry. Selectors 0..F map in order to 70, 73, 75, 7C, A0, B0, 84, 87, 89, 8B, 8D, 8F, 91, 94, 96, 98 (all hex).
- R5: fetch_req_o is high for exactly one cycle, and instr_i is sampled in the cycle after it. cm_addr_o shows the mapped address two cycles after the fetch request. The first control word appears on cdr_o, with ctrl_valid_o high for one cycle, four cycles after the fetch request.
- R6: When the word on cdr_o has bit 0 set, fetch_req_o is high in the same cycle as ctrl_valid_o, and no further words of that routine are presented.
- R7: When the word on cdr_o has bit 0 clear, fetch_req_o stays low, cm_addr_o shows the previous address plus one, and the next word appears two cycles later.
- R8: An all-zero control word is presented like any other word and has no effect except advancing the control address by one.
- R9: An instruction that maps to 0x00 raises halt_o two cycles after its fetch request. After that, halt_o stays high and neither fetch_req_o nor ctrl_valid_o is asserted until reset; a reset restarts fetching.
- R10: The mapping ignores instr_i[7:0] for register forms and instr_i[11:0] for memory-reference forms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 16 | Instruction word, valid in the cycle after fetch_req_o |
| fetch_req_o | output | 1 | Request for the next instruction word |
| cm_addr_o | output | 10 | Control memory read address (control address register) |
| cm_data_i | input | 24 | Control memory read data, one cycle after the address |
| cdr_o | output | 24 | Control data register contents |
| ctrl_valid_o | output | 1 | Pulses for one cycle when cdr_o holds a newly read word |
| halt_o | output | 1 | High once a halt has been decoded |

## Verification
The bound checker watches, on every cycle, the relationships between the ports that must hold whatever the program is. It checks that fetch requests last a single cycle and that the end flag and the fetch request coincide. It checks that continuing and all-zero words advance the control address by exactly one, and that the halted state is sticky and quiet. The bench's scenarios show what no cycle-local property can. These are the mapping table for each opcode form, the four-cycle fetch-to-word latency, the two-cycle spacing between words, the content of each word against a computed memory image, the indifference to operand bits, and the restart after a reset following a halt.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    ST_FETCH,
    ST_DECODE,
    ST_READ,
    ST_LATCH,
    ST_HALT
  } seq_state_e;

  typedef enum logic [1:0] {
    CAR_HOLD,
    CAR_LOAD,
    CAR_INC
  } car_op_e;

  localparam int unsigned MAP_W = 8;
endpackage

// File: rtl/useq_opmap.sv
module useq_opmap
  import useq_pkg::*;
#(
  parameter int unsigned CAR_W = 10
) (
  input  logic [7:0]       op_byte_i,
  output logic [CAR_W-1:0] map_addr_o,
  output logic             map_halt_o
);
  logic [2:0]       opc;
  logic             ind;
  logic [3:0]       sel;
  logic [MAP_W-1:0] entry;

  assign ind = op_byte_i[7];
  assign opc = op_byte_i[6:4];
  assign sel = op_byte_i[3:0];

  function automatic logic [MAP_W-1:0] mem_entry(input logic i, input logic [2:0] o);
    case ({i, o})
      4'h1: return 8'h03;
      4'h2: return 8'h05;
      4'h3: return 8'h07;
      4'h4: return 8'h09;
      4'h5: return 8'h0C;
      4'h6: return 8'h0F;
      4'h7: return 8'h12;
      4'h9: return 8'h17;
      4'hA: return 8'h1A;
      4'hB: return 8'h1D;
      4'hC: return 8'h21;
      4'hD: return 8'h24;
      4'hE: return 8'h27;
      4'hF: return 8'h2A;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [MAP_W-1:0] alu_entry(input logic [3:0] s);
    case (s)
      4'h0: return 8'h30;
      4'h1: return 8'h32;
      4'h2: return 8'h34;
      4'h3: return 8'h4A;
      4'h4: return 8'h36;
      4'h5: return 8'h9A;
      4'h6: return 8'h46;
      4'h7: return 8'h3C;
      4'h8: return 8'h38;
      4'h9: return 8'h3A;
      4'hA: return 8'h3E;
      4'hB: return 8'h40;
      4'hC: return 8'h48;
      4'hD: return 8'h42;
      4'hE: return 8'h44;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [MAP_W-1:0] sys_entry(input logic [3:0] s);
    case (s)
      4'h0: return 8'h70;
      4'h1: return 8'h73;
      4'h2: return 8'h75;
      4'h3: return 8'h7C;
      4'h4: return 8'hA0;
      4'h5: return 8'hB0;
      4'h6: return 8'h84;
      4'h7: return 8'h87;
      4'h8: return 8'h89;
      4'h9: return 8'h8B;
      4'hA: return 8'h8D;
      4'hB: return 8'h8F;
      4'hC: return 8'h91;
      4'hD: return 8'h94;
      4'hE: return 8'h96;
      default: return 8'h98;
    endcase
  endfunction

  always_comb begin
    if (opc != 3'd0) entry = mem_entry(ind, opc);
    else if (ind)    entry = sys_entry(sel);
    else             entry = alu_entry(sel);
  end

  assign map_halt_o = (entry == '0);

  generate
    if (CAR_W > MAP_W) begin : g_widen
      assign map_addr_o = {{(CAR_W-MAP_W){1'b0}}, entry};
    end else begin : g_trunc
      assign map_addr_o = entry[CAR_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/useq_car.sv
module useq_car
  import useq_pkg::*;
#(
  parameter int unsigned CAR_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  car_op_e          op_i,
  input  logic [CAR_W-1:0] load_i,
  output logic [CAR_W-1:0] car_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_o <= '0;
    end else begin
      case (op_i)
        CAR_LOAD: car_o <= load_i;
        CAR_INC:  car_o <= car_o + 1'b1;
        default:  car_o <= car_o;
      endcase
    end
  end
endmodule

// File: rtl/useq_ctl.sv
module useq_ctl
  import useq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    map_halt_i,
  input  logic    end_bit_i,
  output logic    fetch_req_o,
  output car_op_e car_op_o,
  output logic    cdr_load_o,
  output logic    halt_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    car_op_o   = CAR_HOLD;
    cdr_load_o = 1'b0;
    case (state_q)
      ST_FETCH:  state_d = ST_DECODE;
      ST_DECODE: begin
        car_op_o = CAR_LOAD;
        state_d  = map_halt_i ? ST_HALT : ST_READ;
      end
      ST_READ:   state_d = ST_LATCH;  // word appears after this edge
      ST_LATCH: begin
        cdr_load_o = 1'b1;
        if (end_bit_i) begin
          state_d = ST_FETCH;
        end else begin
          car_op_o = CAR_INC;
          state_d  = ST_READ;
        end
      end
      default:   state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  assign fetch_req_o = (state_q == ST_FETCH);
  assign halt_o      = (state_q == ST_HALT);
endmodule

// File: rtl/useq_cdr.sv
module useq_cdr #(
  parameter int unsigned CW_W = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [CW_W-1:0] word_i,
  output logic [CW_W-1:0] cdr_o,
  output logic            valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cdr_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load_i;
      if (load_i) cdr_o <= word_i;
    end
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned CAR_W   = 10,
  parameter int unsigned CW_W    = 24,
  parameter int unsigned END_BIT = 0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  output logic               fetch_req_o,
  output logic [CAR_W-1:0]   cm_addr_o,
  input  logic [CW_W-1:0]    cm_data_i,
  output logic [CW_W-1:0]    cdr_o,
  output logic               ctrl_valid_o,
  output logic               halt_o
);
  localparam int unsigned OPB_LSB = INSTR_W - 8;

  logic [CAR_W-1:0] map_addr;
  logic             map_halt;
  car_op_e          car_op;
  logic             cdr_load;
  logic             unused_operand;

  assign unused_operand = ^instr_i[OPB_LSB-1:0];

  useq_opmap #(.CAR_W(CAR_W)) u_map (
    .op_byte_i (instr_i[INSTR_W-1:OPB_LSB]),
    .map_addr_o(map_addr),
    .map_halt_o(map_halt)
  );

  useq_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .map_halt_i (map_halt),
    .end_bit_i  (cm_data_i[END_BIT]),
    .fetch_req_o(fetch_req_o),
    .car_op_o   (car_op),
    .cdr_load_o (cdr_load),
    .halt_o     (halt_o)
  );

  useq_car #(.CAR_W(CAR_W)) u_car (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .op_i  (car_op),
    .load_i(map_addr),
    .car_o (cm_addr_o)
  );

  useq_cdr #(.CW_W(CW_W)) u_cdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (cdr_load),
    .word_i (cm_data_i),
    .cdr_o  (cdr_o),
    .valid_o(ctrl_valid_o)
  );
endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
  parameter int unsigned CAR_W   = 10,
  parameter int unsigned CW_W    = 24,
  parameter int unsigned END_BIT = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             fetch_req_o,
  input logic [CAR_W-1:0] cm_addr_o,
  input logic [CW_W-1:0]  cdr_o,
  input logic             ctrl_valid_o,
  input logic             halt_o
);
  AST_FETCH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_o |=> !fetch_req_o); // R5

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o |=> !ctrl_valid_o); // R5

  AST_END_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o && cdr_o[END_BIT] |-> fetch_req_o); // R6

  AST_CONT_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o && !cdr_o[END_BIT] |-> !fetch_req_o); // R7

  AST_CONT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o && !cdr_o[END_BIT] |-> cm_addr_o == CAR_W'($past(cm_addr_o) + 1'b1)); // R7

  AST_ZERO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_valid_o && (cdr_o == '0) |-> !fetch_req_o && !halt_o); // R8

  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R9

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !fetch_req_o && !ctrl_valid_o); // R9
endmodule

bind useq_sequencer useq_checker #(
  .CAR_W  (CAR_W),
  .CW_W   (CW_W),
  .END_BIT(END_BIT)
) u_chk (.*);

// File: tb/sim_useq_sequencer.sv
module sim_useq_sequencer;
  localparam int INSTR_W = 16;
  localparam int CAR_W   = 10;
  localparam int CW_W    = 24;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [INSTR_W-1:0] instr_i = '0;
  logic               fetch_req_o;
  logic [CAR_W-1:0]   cm_addr_o;
  logic [CW_W-1:0]    cm_data_i = '0;
  logic [CW_W-1:0]    cdr_o;
  logic               ctrl_valid_o;
  logic               halt_o;

  always #5 clk_i = ~clk_i;

  useq_sequencer u0 (.*);

  int checks = 0;
  int fails  = 0;
  logic [15:0] prog [0:127];

  // Control memory image: every 4th-plus-one address is all zero, bit 0 set when addr % 3 == 0
  function automatic logic [CW_W-1:0] ref_word(input logic [CAR_W-1:0] a);
    if ((a % 10'd4) == 10'd1) return '0;
    return {a ^ 10'h2A5, 5'h13, a[7:0], ((a % 10'd3) == 10'd0)};
  endfunction

  function automatic logic [CAR_W-1:0] ref_map(input logic [15:0] w);
    logic [7:0] e;
    if (w[14:12] != 3'd0) begin
      case (w[14:12])
        3'd1: e = w[15] ? 8'h17 : 8'h03;
        3'd2: e = w[15] ? 8'h1A : 8'h05;
        3'd3: e = w[15] ? 8'h1D : 8'h07;
        3'd4: e = w[15] ? 8'h21 : 8'h09;
        3'd5: e = w[15] ? 8'h24 : 8'h0C;
        3'd6: e = w[15] ? 8'h27 : 8'h0F;
        default: e = w[15] ? 8'h2A : 8'h12;
      endcase
    end else if (!w[15]) begin
      case (w[11:8])
        4'h0: e = 8'h30; 4'h1: e = 8'h32; 4'h2: e = 8'h34; 4'h3: e = 8'h4A;
        4'h4: e = 8'h36; 4'h5: e = 8'h9A; 4'h6: e = 8'h46; 4'h7: e = 8'h3C;
        4'h8: e = 8'h38; 4'h9: e = 8'h3A; 4'hA: e = 8'h3E; 4'hB: e = 8'h40;
        4'hC: e = 8'h48; 4'hD: e = 8'h42; 4'hE: e = 8'h44; default: e = 8'h00;
      endcase
    end else begin
      case (w[11:8])
        4'h0: e = 8'h70; 4'h1: e = 8'h73; 4'h2: e = 8'h75; 4'h3: e = 8'h7C;
        4'h4: e = 8'hA0; 4'h5: e = 8'hB0; 4'h6: e = 8'h84; 4'h7: e = 8'h87;
        4'h8: e = 8'h89; 4'h9: e = 8'h8B; 4'hA: e = 8'h8D; 4'hB: e = 8'h8F;
        4'hC: e = 8'h91; 4'hD: e = 8'h94; 4'hE: e = 8'h96; default: e = 8'h98;
      endcase
    end
    return {2'b00, e};
  endfunction

  function automatic string map_tag(input logic [15:0] w);
    if (w[14:12] != 3'd0) return "R2";
    if (!w[15]) return "R3";
    return "R4";
  endfunction

  function automatic bit operand_nonzero(input logic [15:0] w);
    if (w[14:12] != 3'd0) return w[11:0] != 12'h000;
    return w[7:0] != 8'h00;
  endfunction

  always @(posedge clk_i) cm_data_i <= ref_word(cm_addr_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(cm_addr_o == '0 && cdr_o == '0 && !ctrl_valid_o && !halt_o, "R1 reset state",
        {cm_addr_o, cdr_o[7:0], ctrl_valid_o, halt_o}, 32'h0);
    rst_ni = 1'b1;
    chk(fetch_req_o == 1'b1, "R1 first fetch", fetch_req_o, 1);
  endtask

  task automatic run_phase(input int len);
    int pc = 0, cyc = 0, fcyc = -100, lastv = -100, halt_at = -1, idle = 0;
    bit busy = 0, first = 0, halted = 0, done = 0;
    logic [15:0]      cur;
    logic [CAR_W-1:0] start_a = '0, exp_a = '0;
    logic [CW_W-1:0]  w;
    for (int n = 0; n < 20000; n++) begin
      if (ctrl_valid_o && !halted) begin
        w = ref_word(exp_a);
        if (!busy) chk(0, "R6 word outside routine", cdr_o, 0);
        if (w == '0) chk(cdr_o == w, "R8 zero word", cdr_o, w);
        else         chk(cdr_o == w, first ? "R5 first word" : "R7 next word", cdr_o, w);
        if (first) chk(cyc == fcyc + 4, "R5 latency", cyc - fcyc, 4);
        else       chk(cyc == lastv + 2, "R7 spacing", cyc - lastv, 2);
        lastv = cyc;
        first = 0;
        if (w[0]) begin
          chk(fetch_req_o, "R6 end fetch", fetch_req_o, 1);
          busy = 0;
        end else begin
          chk(!fetch_req_o && cm_addr_o == exp_a + 1'b1, (w == '0) ? "R8 advance" : "R7 advance",
              {fetch_req_o, cm_addr_o}, {1'b0, exp_a + 1'b1});
          exp_a = exp_a + 1'b1;
        end
      end
      if (fetch_req_o && !halted) begin
        chk(!busy, "R6 fetch before end", busy, 0);
        if (pc >= len) begin
          chk(0, "R9 fetch past halt", pc, len);
        end else begin
          cur = prog[pc];
          pc++;
          instr_i = cur;
          start_a = ref_map(cur);
          exp_a = start_a;
          fcyc = cyc;
          first = 1;
          if (start_a == '0) halt_at = cyc + 2;
          else busy = 1;
        end
      end
      if (cyc == fcyc + 1) chk(!fetch_req_o, "R5 fetch pulse", fetch_req_o, 0);
      if (cyc == fcyc + 2 && !halted) begin
        chk(cm_addr_o == start_a, map_tag(cur), cm_addr_o, start_a);
        if (operand_nonzero(cur)) chk(cm_addr_o == start_a, "R10 operand ignored", cm_addr_o, start_a);
      end
      if (cyc == halt_at) begin
        chk(halt_o, "R9 halt", halt_o, 1);
        halted = 1;
      end else if (halted) begin
        chk(halt_o && !fetch_req_o && !ctrl_valid_o, "R9 sticky",
            {halt_o, fetch_req_o, ctrl_valid_o}, 3'b100);
        idle++;
        if (idle == 20) begin
          done = 1;
          break;
        end
      end
      @(negedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: phase did not complete, actual %0d expected %0d", pc, len);
    end
  endtask

  initial begin
    int n;
    logic [15:0] r;
    r = 16'($urandom(32'd20240));
    // phase 1: directed corner cases then random, ending in a halt
    prog[0]  = 16'h1000; prog[1]  = 16'h9FFF; prog[2]  = 16'h2000; prog[3]  = 16'hA123;
    prog[4]  = 16'h3456; prog[5]  = 16'hB000; prog[6]  = 16'h4001; prog[7]  = 16'hC000;
    prog[8]  = 16'h5000; prog[9]  = 16'hD000; prog[10] = 16'h6000; prog[11] = 16'hE000;
    prog[12] = 16'h7ABC; prog[13] = 16'hF000; prog[14] = 16'h0000; prog[15] = 16'h00FF;
    prog[16] = 16'h0E00; prog[17] = 16'h0E55; prog[18] = 16'h8000; prog[19] = 16'h8600;
    prog[20] = 16'h8400; prog[21] = 16'h8500; prog[22] = 16'h8F12; prog[23] = 16'h8FFF;
    prog[24] = 16'h0500; prog[25] = 16'h0300;
    n = 26;
    for (int i = 0; i < 60; i++) begin
      r = 16'($urandom);
      if (r[15:12] == 4'h0 && r[11:8] == 4'hF) r[11:8] = 4'h7;
      prog[n] = r;
      n++;
    end
    prog[n] = 16'h0F00;
    n++;
    do_reset();
    run_phase(n);
    // phase 2: reset after halt restarts fetching; halt with nonzero operand
    prog[0] = 16'h0200; prog[1] = 16'hC000; prog[2] = 16'h8B00; prog[3] = 16'h0F7E;
    do_reset();
    run_phase(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule